// File: doc/BRIEF.md
# Multi-Port GPIO Register Bank with APB Access

This block is a memory-mapped general-purpose I/O bank on an APB slave. It holds up to four ports, each as wide as a parameter allows (at most 32 bits). Each port has three registers:

- an output-value register, which drives the pads;
- a direction register, which drives the per-pad output enables;
- a read-only input register, which returns the pad level after a two-flop synchronizer.

The first port (port A) also holds the configuration of its interrupt unit. This covers the enable, mask, edge/level type, polarity and debounce-enable registers. The interrupt unit's pending status comes in on an input port and is read through the bus. An end-of-interrupt write appears as a one-cycle bit pulse for the interrupt unit.

The interrupt unit itself lives in a separate block. A static strap input selects between two placements of the interrupt registers in the address map. Writes take effect in the APB access phase. The bank never inserts wait states and never signals an error. Read data is combinational from the address during any read transfer.

Top module: `gpio_apb_bank`

## Requirements
- R1: After reset, every output-value, direction and interrupt-configuration register is zero, so `pad_out` and `pad_oe` are all zero.
- R2: The output-value register of port n (n = 0..3) is at byte offset 0x00 + 0x0C*n, that is 0x00, 0x0C, 0x18 and 0x24. A write drives `pad_out` slice n from the next cycle, and a read returns the stored value.
- R3: The direction register of port n is at 0x04 + 0x0C*n. A bit value of 1 makes that pad an output, raising its bit of `pad_oe` from the cycle after the write.
- R4: The input register of port n is at 0x50 + 4*n. It returns the pad level two clock edges after the pad changes, whatever the direction setting. Writes to it change nothing.
- R5: With `alt_map_i` low, the interrupt registers sit at these offsets: enable 0x30, mask 0x34, type 0x38 (1 = edge), polarity 0x3C, status 0x40, debounce 0x48 and end-of-interrupt 0x4C. Status is read-only and returns `irq_status_i`. Each configuration register drives its own output port.
- R6: With `alt_map_i` high, mask moves to 0x44, type to 0x34, polarity to 0x38, status to 0x3C and end-of-interrupt to 0x40. Enable stays at 0x30 and debounce stays at 0x48, and 0x4C becomes unmapped.
- R7: A write to the end-of-interrupt register places the written bits on `eoi_o` for exactly the one cycle after the write. Reads of that offset return zero.
- R8: Some offsets are unmapped: the holes at 0x08, 0x14, 0x20 and 0x2C, the unused interrupt slot of the active map, offsets of 0x60 and above, offsets not a multiple of four, and the registers of ports beyond `NUM_PORTS`. Reads of these return zero, and writes to them change nothing.
- R9: Registers change only when `psel`, `penable` and `pwrite` are all high at a clock edge. A setup-phase cycle or a read changes nothing. `pready` is always 1 and `pslverr` is always 0.
- R10: Register bits above `PORT_W` are not stored and read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write transfer |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during a read transfer |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always zero |
| alt_map_i | input | 1 | Interrupt-register placement strap |
| pad_in | input | NUM_PORTS*PORT_W | Raw pad levels, port 0 in the low slice |
| pad_out | output | NUM_PORTS*PORT_W | Pad output values |
| pad_oe | output | NUM_PORTS*PORT_W | Pad output enables |
| irq_status_i | input | PORT_W | Pending status from the interrupt unit |
| irq_en_o | output | PORT_W | Interrupt enable bits |
| irq_mask_o | output | PORT_W | Interrupt mask bits |
| irq_edge_o | output | PORT_W | 1 = edge-triggered, 0 = level |
| irq_pol_o | output | PORT_W | 1 = high/rising active |
| dbnc_en_o | output | PORT_W | Debounce enable bits |
| eoi_o | output | PORT_W | One-cycle end-of-interrupt clear bits |

## Verification
The bench builds the bank with `NUM_PORTS` = 3, `PORT_W` = 16 and `ADDR_W` = 8. With three ports, the fourth port's data and direction offsets become unmapped, so absent-port accesses can be observed through the same decode path as the holes. The 16-bit width makes the upper halves of written words land in bits the bank must drop, which shows the truncation on readback. The strap is toggled between vectors, so the same stored values are seen at both placements.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned BUS_W = 32;

  typedef enum logic [3:0] {
    RK_NONE,
    RK_DATA,
    RK_DIR,
    RK_EXT,
    RK_IEN,
    RK_IMASK,
    RK_ITYPE,
    RK_IPOL,
    RK_ISTAT,
    RK_DBNC,
    RK_EOI
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [1:0] port;
  } reg_sel_t;

  // Word index (byte offset / 4) to register; alt picks the second interrupt layout.
  function automatic reg_sel_t decode_word(input logic [5:0] word, input logic alt);
    reg_sel_t s;
    s.kind = RK_NONE;
    s.port = 2'd0;
    if (word < 6'd12) begin
      // data/direction pairs, three words per port
      s.port = 2'(word / 6'd3);
      if ((word % 6'd3) == 6'd0)      s.kind = RK_DATA;
      else if ((word % 6'd3) == 6'd1) s.kind = RK_DIR;
    end else if (word >= 6'd20 && word <= 6'd23) begin
      s.kind = RK_EXT;
      s.port = word[1:0];
    end else begin
      case (word)
        6'd12:   s.kind = RK_IEN;
        6'd13:   s.kind = alt ? RK_ITYPE : RK_IMASK;
        6'd14:   s.kind = alt ? RK_IPOL  : RK_ITYPE;
        6'd15:   s.kind = alt ? RK_ISTAT : RK_IPOL;
        6'd16:   s.kind = alt ? RK_EOI   : RK_ISTAT;
        6'd17:   s.kind = alt ? RK_IMASK : RK_NONE;
        6'd18:   s.kind = RK_DBNC;
        6'd19:   s.kind = alt ? RK_NONE  : RK_EOI;
        default: s.kind = RK_NONE;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_PORTS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              alt,
  output reg_kind_e         kind,
  output logic [1:0]        port
);

  logic     hi_zero;
  reg_sel_t raw;

  generate
    if (ADDR_W > 8) begin : g_hi
      assign hi_zero = ~|addr[ADDR_W-1:8];
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    raw  = decode_word(addr[7:2], alt);
    kind = raw.kind;
    port = raw.port;
    if (!hi_zero || (addr[1:0] != 2'b00)) kind = RK_NONE;
    if ((raw.kind inside {RK_DATA, RK_DIR, RK_EXT}) && (int'(raw.port) >= NUM_PORTS))
      kind = RK_NONE;
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int PORT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_data,
  input  logic              we_dir,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] data_q,
  output logic [PORT_W-1:0] dir_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (we_data) data_q <= wdata;
      if (we_dir)  dir_q  <= wdata;
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= (s == 0) ? d : stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg #(
  parameter int PORT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_en,
  input  logic              we_mask,
  input  logic              we_type,
  input  logic              we_pol,
  input  logic              we_dbnc,
  input  logic              we_eoi,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] en_q,
  output logic [PORT_W-1:0] mask_q,
  output logic [PORT_W-1:0] edge_q,
  output logic [PORT_W-1:0] pol_q,
  output logic [PORT_W-1:0] dbnc_q,
  output logic [PORT_W-1:0] eoi_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      edge_q <= '0;
      pol_q  <= '0;
      dbnc_q <= '0;
      eoi_q  <= '0;
    end else begin
      if (we_en)   en_q   <= wdata;
      if (we_mask) mask_q <= wdata;
      if (we_type) edge_q <= wdata;
      if (we_pol)  pol_q  <= wdata;
      if (we_dbnc) dbnc_q <= wdata;
      // clear bits live for exactly one cycle
      eoi_q <= we_eoi ? wdata : '0;
    end
  end

endmodule

// File: rtl/gpio_apb_bank.sv
module gpio_apb_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int PORT_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        pclk,
  input  logic                        presetn,
  input  logic                        psel,
  input  logic                        penable,
  input  logic                        pwrite,
  input  logic [ADDR_W-1:0]           paddr,
  input  logic [BUS_W-1:0]            pwdata,
  output logic [BUS_W-1:0]            prdata,
  output logic                        pready,
  output logic                        pslverr,
  input  logic                        alt_map_i,
  input  logic [NUM_PORTS*PORT_W-1:0] pad_in,
  output logic [NUM_PORTS*PORT_W-1:0] pad_out,
  output logic [NUM_PORTS*PORT_W-1:0] pad_oe,
  input  logic [PORT_W-1:0]           irq_status_i,
  output logic [PORT_W-1:0]           irq_en_o,
  output logic [PORT_W-1:0]           irq_mask_o,
  output logic [PORT_W-1:0]           irq_edge_o,
  output logic [PORT_W-1:0]           irq_pol_o,
  output logic [PORT_W-1:0]           dbnc_en_o,
  output logic [PORT_W-1:0]           eoi_o
);

  localparam int PADS_W = NUM_PORTS * PORT_W;

  // named internal events, visible to the bound checker
  logic              wr_fire;
  logic              rd_sel;
  reg_kind_e         dec_kind;
  logic [1:0]        dec_port;
  logic [PORT_W-1:0] wdata_w;
  logic [PADS_W-1:0] ext_sync;
  logic [PORT_W-1:0] sync_a;
  logic [PORT_W-1:0] rd_val;

  logic [PORT_W-1:0] data_q [NUM_PORTS];
  logic [PORT_W-1:0] dir_q  [NUM_PORTS];

  assign wr_fire = psel & penable & pwrite;
  assign rd_sel  = psel & ~pwrite;
  assign wdata_w = pwdata[PORT_W-1:0];
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  gpio_addr_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_PORTS(NUM_PORTS)
  ) u_dec (
    .addr(paddr),
    .alt (alt_map_i),
    .kind(dec_kind),
    .port(dec_port)
  );

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      gpio_port_regs #(.PORT_W(PORT_W)) u_regs (
        .clk    (pclk),
        .rst_n  (presetn),
        .we_data(wr_fire && dec_kind == RK_DATA && dec_port == 2'(p)),
        .we_dir (wr_fire && dec_kind == RK_DIR  && dec_port == 2'(p)),
        .wdata  (wdata_w),
        .data_q (data_q[p]),
        .dir_q  (dir_q[p])
      );
      assign pad_out[p*PORT_W +: PORT_W] = data_q[p];
      assign pad_oe [p*PORT_W +: PORT_W] = dir_q[p];
    end
  endgenerate

  gpio_in_sync #(.W(PADS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (pclk),
    .rst_n(presetn),
    .d    (pad_in),
    .q    (ext_sync)
  );
  assign sync_a = ext_sync[PORT_W-1:0];

  gpio_irq_cfg #(.PORT_W(PORT_W)) u_irq (
    .clk    (pclk),
    .rst_n  (presetn),
    .we_en  (wr_fire && dec_kind == RK_IEN),
    .we_mask(wr_fire && dec_kind == RK_IMASK),
    .we_type(wr_fire && dec_kind == RK_ITYPE),
    .we_pol (wr_fire && dec_kind == RK_IPOL),
    .we_dbnc(wr_fire && dec_kind == RK_DBNC),
    .we_eoi (wr_fire && dec_kind == RK_EOI),
    .wdata  (wdata_w),
    .en_q   (irq_en_o),
    .mask_q (irq_mask_o),
    .edge_q (irq_edge_o),
    .pol_q  (irq_pol_o),
    .dbnc_q (dbnc_en_o),
    .eoi_q  (eoi_o)
  );

  always_comb begin
    rd_val = '0;
    case (dec_kind)
      RK_DATA: for (int p = 0; p < NUM_PORTS; p++) if (dec_port == 2'(p)) rd_val = data_q[p];
      RK_DIR:  for (int p = 0; p < NUM_PORTS; p++) if (dec_port == 2'(p)) rd_val = dir_q[p];
      RK_EXT:  for (int p = 0; p < NUM_PORTS; p++)
                 if (dec_port == 2'(p)) rd_val = ext_sync[p*PORT_W +: PORT_W];
      RK_IEN:   rd_val = irq_en_o;
      RK_IMASK: rd_val = irq_mask_o;
      RK_ITYPE: rd_val = irq_edge_o;
      RK_IPOL:  rd_val = irq_pol_o;
      RK_ISTAT: rd_val = irq_status_i;
      RK_DBNC:  rd_val = dbnc_en_o;
      default:  rd_val = '0;
    endcase
  end

  assign prdata = rd_sel ? BUS_W'(rd_val) : '0;

endmodule

// File: rtl/gpio_apb_bank_chk.sv
module gpio_apb_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int PORT_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic                        pclk,
  input logic                        presetn,
  input logic                        psel,
  input logic                        pwrite,
  input logic [ADDR_W-1:0]           paddr,
  input logic [BUS_W-1:0]            pwdata,
  input logic [BUS_W-1:0]            prdata,
  input logic                        alt_map_i,
  input logic [PORT_W-1:0]           pad_in_a,
  input logic [NUM_PORTS*PORT_W-1:0] pad_out,
  input logic [NUM_PORTS*PORT_W-1:0] pad_oe,
  input logic [PORT_W-1:0]           irq_status_i,
  input logic [PORT_W-1:0]           eoi_o,
  input logic                        wr_fire,
  input reg_kind_e                   dec_kind,
  input logic [1:0]                  dec_port,
  input logic [PORT_W-1:0]           sync_a
);

  logic [1:0] cyc;
  logic       rd;

  assign rd = psel & ~pwrite;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)          cyc <= '0;
    else if (cyc != 2'd3)  cyc <= cyc + 2'd1;
  end

  assert_oe_load_R3: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_fire && dec_kind == RK_DIR && dec_port == 2'd0)
      |=> pad_oe[PORT_W-1:0] == $past(pwdata[PORT_W-1:0]));

  assert_pads_hold_R9: assert property (@(posedge pclk) disable iff (!presetn)
    !wr_fire |=> ($stable(pad_out) && $stable(pad_oe)));

  generate
    if (SYNC_STAGES == 2) begin : g_sync_chk
      assert_sync_delay_R4: assert property (@(posedge pclk) disable iff (!presetn)
        (cyc >= 2'd2) |-> sync_a == $past(pad_in_a, 2));
    end
  endgenerate

  assert_eoi_source_R7: assert property (@(posedge pclk) disable iff (!presetn)
    (|eoi_o) |-> $past(wr_fire));

  assert_eoi_single_R7: assert property (@(posedge pclk) disable iff (!presetn)
    (|eoi_o) |=> !(|eoi_o));

  assert_hole_zero_R8: assert property (@(posedge pclk) disable iff (!presetn)
    (rd && paddr == ADDR_W'('h08)) |-> prdata == '0);

  assert_status_dflt_R5: assert property (@(posedge pclk) disable iff (!presetn)
    (rd && !alt_map_i && paddr == ADDR_W'('h40)) |-> prdata == BUS_W'(irq_status_i));

  assert_status_alt_R6: assert property (@(posedge pclk) disable iff (!presetn)
    (rd && alt_map_i && paddr == ADDR_W'('h3C)) |-> prdata == BUS_W'(irq_status_i));

endmodule

bind gpio_apb_bank gpio_apb_bank_chk #(
  .NUM_PORTS  (NUM_PORTS),
  .PORT_W     (PORT_W),
  .ADDR_W     (ADDR_W),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .pclk        (pclk),
  .presetn     (presetn),
  .psel        (psel),
  .pwrite      (pwrite),
  .paddr       (paddr),
  .pwdata      (pwdata),
  .prdata      (prdata),
  .alt_map_i   (alt_map_i),
  .pad_in_a    (pad_in[PORT_W-1:0]),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .irq_status_i(irq_status_i),
  .eoi_o       (eoi_o),
  .wr_fire     (wr_fire),
  .dec_kind    (dec_kind),
  .dec_port    (dec_port),
  .sync_a      (sync_a)
);

// File: tb/test_gpio_apb_bank.sv
module test_gpio_apb_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int PW = 16;
  localparam int AW = 8;

  typedef struct packed {
    logic        wr;
    logic        alt;
    logic [3:0]  req;
    logic [7:0]  addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 4'd2,  8'h00, 32'h1234A5A5},  // R2 port A value
    '{1'b0, 1'b0, 4'd10, 8'h00, 32'h0000A5A5},  // R10 upper half dropped
    '{1'b1, 1'b0, 4'd2,  8'h0C, 32'h0000BEEF},  // R2 port B
    '{1'b0, 1'b0, 4'd2,  8'h0C, 32'h0000BEEF},
    '{1'b1, 1'b0, 4'd2,  8'h18, 32'h00000F0F},  // R2 port C
    '{1'b0, 1'b0, 4'd2,  8'h18, 32'h00000F0F},
    '{1'b1, 1'b0, 4'd3,  8'h04, 32'h0000FFFF},  // R3 port A direction
    '{1'b0, 1'b0, 4'd3,  8'h04, 32'h0000FFFF},
    '{1'b1, 1'b0, 4'd3,  8'h10, 32'h00FF00F0},  // R3 port B direction
    '{1'b0, 1'b0, 4'd10, 8'h10, 32'h000000F0},
    '{1'b1, 1'b0, 4'd3,  8'h1C, 32'h00000001},  // R3 port C direction
    '{1'b0, 1'b0, 4'd3,  8'h1C, 32'h00000001},
    '{1'b1, 1'b0, 4'd8,  8'h24, 32'h00005555},  // R8 absent port D
    '{1'b0, 1'b0, 4'd8,  8'h24, 32'h00000000},
    '{1'b1, 1'b0, 4'd8,  8'h08, 32'h0000FFFF},  // R8 hole
    '{1'b0, 1'b0, 4'd8,  8'h08, 32'h00000000},
    '{1'b1, 1'b0, 4'd5,  8'h30, 32'h000000AA},  // R5 enable
    '{1'b0, 1'b0, 4'd5,  8'h30, 32'h000000AA},
    '{1'b1, 1'b0, 4'd5,  8'h34, 32'h0000000F},  // R5 mask
    '{1'b0, 1'b0, 4'd5,  8'h34, 32'h0000000F},
    '{1'b1, 1'b0, 4'd5,  8'h38, 32'h000000F0},  // R5 type
    '{1'b0, 1'b0, 4'd5,  8'h38, 32'h000000F0},
    '{1'b1, 1'b0, 4'd5,  8'h3C, 32'h00000F00},  // R5 polarity
    '{1'b0, 1'b0, 4'd5,  8'h3C, 32'h00000F00},
    '{1'b1, 1'b0, 4'd5,  8'h48, 32'h00000003},  // R5 debounce
    '{1'b0, 1'b0, 4'd5,  8'h48, 32'h00000003},
    '{1'b0, 1'b0, 4'd8,  8'h44, 32'h00000000},  // R8 unused slot, default map
    '{1'b0, 1'b0, 4'd8,  8'h60, 32'h00000000},  // R8 beyond map
    '{1'b0, 1'b0, 4'd8,  8'h31, 32'h00000000},  // R8 unaligned
    '{1'b0, 1'b0, 4'd5,  8'h40, 32'h0000C3A5},  // R5 status
    '{1'b1, 1'b0, 4'd5,  8'h40, 32'h0000FFFF},  // R5 status is read-only
    '{1'b0, 1'b0, 4'd5,  8'h40, 32'h0000C3A5},
    '{1'b0, 1'b1, 4'd6,  8'h34, 32'h000000F0},  // R6 type moved
    '{1'b0, 1'b1, 4'd6,  8'h38, 32'h00000F00},  // R6 polarity moved
    '{1'b0, 1'b1, 4'd6,  8'h44, 32'h0000000F},  // R6 mask moved
    '{1'b0, 1'b1, 4'd6,  8'h30, 32'h000000AA},  // R6 enable kept
    '{1'b0, 1'b1, 4'd6,  8'h48, 32'h00000003},  // R6 debounce kept
    '{1'b0, 1'b1, 4'd6,  8'h3C, 32'h0000C3A5},  // R6 status moved
    '{1'b1, 1'b1, 4'd6,  8'h44, 32'h00000033},  // R6 write mask at new slot
    '{1'b0, 1'b1, 4'd6,  8'h44, 32'h00000033},
    '{1'b0, 1'b1, 4'd6,  8'h4C, 32'h00000000},  // R6 0x4C unmapped
    '{1'b0, 1'b0, 4'd6,  8'h34, 32'h00000033}   // R6 same mask back at default slot
  };

  logic           pclk = 1'b0;
  logic           presetn = 1'b0;
  logic           psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0]  paddr = '0;
  logic [31:0]    pwdata = '0;
  logic [31:0]    prdata;
  logic           pready, pslverr;
  logic           alt_map_i = 1'b0;
  logic [NP*PW-1:0] pad_in = '0;
  logic [NP*PW-1:0] pad_out, pad_oe;
  logic [PW-1:0]  irq_status_i = 16'hC3A5;
  logic [PW-1:0]  irq_en_o, irq_mask_o, irq_edge_o, irq_pol_o, dbnc_en_o, eoi_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  gpio_apb_bank #(.NUM_PORTS(NP), .PORT_W(PW), .ADDR_W(AW)) i_gpio_apb_bank (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .alt_map_i(alt_map_i), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_status_i(irq_status_i), .irq_en_o(irq_en_o), .irq_mask_o(irq_mask_o),
    .irq_edge_o(irq_edge_o), .irq_pol_o(irq_pol_o), .dbnc_en_o(dbnc_en_o), .eoi_o(eoi_o)
  );

  always #(CLK_PERIOD/2) pclk = ~pclk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge pclk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);

    // R1 reset state
    check("R1 pad_out", 64'(pad_out), 64'h0);
    check("R1 pad_oe", 64'(pad_oe), 64'h0);
    check("R1 irq cfg", 64'({irq_en_o, irq_mask_o, irq_edge_o, irq_pol_o}), 64'h0);
    check("R1 dbnc/eoi", 64'({dbnc_en_o, eoi_o}), 64'h0);
    apb_read(8'h04, rd);
    check("R1 dir read", 64'(rd), 64'h0);
    // R9 no wait states, no error
    check("R9 pready/pslverr", 64'({pready, pslverr}), 64'h2);

    // vector table
    for (int i = 0; i < NV; i++) begin
      alt_map_i = VECS[i].alt;
      if (VECS[i].wr) begin
        apb_write(VECS[i].addr, VECS[i].data);
      end else begin
        apb_read(VECS[i].addr, rd);
        checks++;
        if (rd !== VECS[i].data) begin
          errors++;
          $display("FAIL R%0d vector %0d addr %h: actual %h expected %h",
                   VECS[i].req, i, VECS[i].addr, rd, VECS[i].data);
        end
      end
    end
    alt_map_i = 1'b0;

    // R2 R3 R8 pads after the table, nothing from the absent port or the hole
    check("R2 pad_out", 64'(pad_out), 64'({16'h0F0F, 16'hBEEF, 16'hA5A5}));
    check("R3 pad_oe", 64'(pad_oe), 64'({16'h0001, 16'h00F0, 16'hFFFF}));
    check("R5 cfg outputs", 64'({irq_en_o, irq_mask_o, irq_edge_o, irq_pol_o}),
          64'({16'h00AA, 16'h0033, 16'h00F0, 16'h0F00}));
    check("R5 dbnc", 64'(dbnc_en_o), 64'h3);

    // R9 setup phase only: no write
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 8'h00; pwdata = 32'h0000FFFF;
    @(negedge pclk);
    psel = 1'b0; pwrite = 1'b0;
    @(negedge pclk);
    check("R9 setup-only write", 64'(pad_out[15:0]), 64'hA5A5);

    // R4 synchronizer latency on port B (an output pad: direction ignored)
    @(negedge pclk);
    pad_in = {16'h0000, 16'h1357, 16'h0000};
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = 8'h54;
    #1 check("R4 before edge", 64'(prdata), 64'h0);
    @(negedge pclk);
    #1 check("R4 after one edge", 64'(prdata), 64'h0);
    @(negedge pclk);
    #1 check("R4 after two edges", 64'(prdata), 64'h1357);
    psel = 1'b0;

    // R4 write to input register has no effect
    apb_write(8'h54, 32'h0000FFFF);
    apb_read(8'h54, rd);
    check("R4 write ignored", 64'(rd), 64'h1357);
    check("R4 write ignored pads", 64'(pad_out), 64'({16'h0F0F, 16'hBEEF, 16'hA5A5}));

    // R7 end-of-interrupt pulse, default map
    apb_write(8'h4C, 32'h00000081);
    check("R7 eoi pulse", 64'(eoi_o), 64'h81);
    @(negedge pclk);
    check("R7 eoi cleared", 64'(eoi_o), 64'h0);
    apb_read(8'h4C, rd);
    check("R7 eoi reads zero", 64'(rd), 64'h0);

    // R6 end-of-interrupt at alternate slot
    alt_map_i = 1'b1;
    apb_write(8'h40, 32'h00000042);
    check("R6 alt eoi pulse", 64'(eoi_o), 64'h42);
    @(negedge pclk);
    check("R6 alt eoi cleared", 64'(eoi_o), 64'h0);
    apb_write(8'h4C, 32'h0000FFFF);
    check("R6 0x4C no eoi", 64'(eoi_o), 64'h0);
    alt_map_i = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule